// File: doc/BRIEF.md
# Bus Cycle Stall Watchdog

This block sits next to a CPU with a multiplexed 8-bit address/data bus and detects stalled machine cycles. The CPU raises its address latch enable (ALE) at the start of every machine cycle. Each rising edge of ALE restarts an internal counter. If the counter reaches its programmed limit before another rising edge arrives, the block declares a stall. This happens when the CPU has halted or is stuck waiting for a ready signal that never comes.

While a stall is declared, the block can override the ready line given to the CPU. The CPU then completes the hung cycle and moves on. The stall is also exported as an active-low bus-level status line. When bus activity resumes after a stall, the block issues a single-clock interrupt request so that software can record the event. The request comes at recovery, not at the moment of timeout.

ALE is asynchronous to the block clock, so it is synchronized and edge-detected inside the block. The timeout interval is a parameter counted in clock cycles. Its default is 2,000,000 cycles, which is 10 ms at 200 MHz.

Top module: `bus_stall_watchdog`

## Requirements
- R1: While rst_n is low, stall_flag is 0, stall_n is 1 and recov_irq is 0. After reset is released, the counter starts from zero.
- R2: stall_flag becomes 1 when TIMEOUT_CYCLES clock edges have passed since reset or since the last detected ALE rising edge, with no rising edge in between. A rising edge detected one cycle before the limit is reached keeps stall_flag at 0.
- R3: Only a 0-to-1 transition of ale_in restarts the count. Holding ale_in high, or holding it low, does not prevent the stall.
- R4: stall_n is always the inverse of stall_flag.
- R5: When force_rdy_en is 1 and stall_flag is 1, rdy_out is 1 whatever the value of rdy_req.
- R6: When force_rdy_en is 0, or when no stall is declared, rdy_out equals rdy_req in the same cycle.
- R7: recov_irq is high for exactly one clock, in the cycle in which a stall is cleared by a detected ALE rising edge. No pulse occurs for a rising edge that arrives while no stall is declared.
- R8: Once a stall is declared, a rise of ale_in clears stall_flag on the (SYNC_STAGES+1)-th rising clock edge after the input rises. Two synchronizer stages and one edge-detect register lie in this path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ale_in | input | 1 | Address latch enable from the CPU, asynchronous |
| rdy_req | input | 1 | Normal ready request to the CPU |
| force_rdy_en | input | 1 | Allows a stall to force ready active |
| stall_flag | output | 1 | High while a stall is declared |
| stall_n | output | 1 | Active-low bus-level stall status |
| rdy_out | output | 1 | Ready line presented to the CPU |
| recov_irq | output | 1 | One-clock interrupt request on recovery from a stall |

## Verification
Two functions can fall in the same cycle: the counter reaching its limit, and the detection of an ALE rising edge. A rising edge detected exactly at the limit must give an interrupt and clear the stall. A rising edge detected one cycle earlier must give neither. The bench provokes both cases by sweeping the ALE pulse period across the timeout interval. It judges every cycle against a behavioural model that tracks elapsed cycles as an integer. The interrupt and the release of the forced ready also coincide, and both are compared in that same cycle.

// File: rtl/bus_stall_watchdog.sv
module bus_stall_watchdog #(
  parameter int TIMEOUT_CYCLES = 2_000_000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ale_in,
  input  logic rdy_req,
  input  logic force_rdy_en,
  output logic stall_flag,
  output logic stall_n,
  output logic rdy_out,
  output logic recov_irq
);

  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYCLES);

  logic [SYNC_STAGES-1:0] ale_sync;
  logic                   ale_prev;
  logic                   ale_rise;
  logic [CW-1:0]          cnt;
  logic                   irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_sync <= '0;
      ale_prev <= 1'b0;
    end else begin
      ale_sync <= {ale_sync[SYNC_STAGES-2:0], ale_in};
      ale_prev <= ale_sync[SYNC_STAGES-1];
    end
  end

  assign ale_rise = ale_sync[SYNC_STAGES-1] & ~ale_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (ale_rise)      cnt <= '0;
    else if (cnt != LIMIT)  cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= ale_rise & stall_flag;
  end

  assign stall_flag = (cnt == LIMIT);
  assign stall_n    = ~stall_flag;
  assign rdy_out    = rdy_req | (force_rdy_en & stall_flag);
  assign recov_irq  = irq_q;

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) recov_irq |=> !recov_irq); // R7
  AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) recov_irq |-> (!stall_flag && $past(stall_flag))); // R7
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (stall_flag && !ale_rise) |=> stall_flag); // R2
  AST_STALL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) $rose(stall_flag) |-> !$past(ale_rise)); // R3
  AST_FORCE_READY: assert property (@(posedge clk) disable iff (!rst_n) (force_rdy_en && stall_flag) |-> rdy_out); // R5
  AST_STATUS_POLARITY: assert property (@(posedge clk) disable iff (!rst_n) stall_n != stall_flag); // R4

endmodule

// File: tb/bus_stall_watchdog_tb.sv
module bus_stall_watchdog_tb;
  localparam int LIM  = 20;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ale = 1'b0, rdy_req = 1'b0, force_en = 1'b0;
  logic stall, stall_n, rdy, irq;

  int checks = 0, errors = 0;
  bit compare_on = 0;

  always #2.5 clk = ~clk;

  bus_stall_watchdog #(.TIMEOUT_CYCLES(LIM), .SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ale_in(ale), .rdy_req(rdy_req),
    .force_rdy_en(force_en), .stall_flag(stall), .stall_n(stall_n),
    .rdy_out(rdy), .recov_irq(irq));

  int m_cnt = 0;
  bit m_irq = 0;
  bit hist[$];

  initial for (int i = 0; i <= SYNC; i++) hist.push_back(1'b0);

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_irq = 0;
      foreach (hist[i]) hist[i] = 1'b0;
    end else begin
      bit r;
      r = hist[SYNC-1] && !hist[SYNC];
      m_irq = r && (m_cnt == LIM);
      if (r) m_cnt = 0;
      else if (m_cnt < LIM) m_cnt = m_cnt + 1;
      hist.push_front(ale);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (compare_on && rst_n) begin
    bit es;
    es = (m_cnt == LIM);
    chk("R2", "stall_flag", stall, es);
    chk("R4", "stall_n", stall_n, !es);
    chk(force_en ? "R5" : "R6", "rdy_out", rdy, rdy_req | (force_en & es));
    chk("R7", "recov_irq", irq, m_irq);
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(input int hi, input int lo);
    ale = 1'b1; tick(hi);
    ale = 1'b0; tick(lo);
  endtask

  int lfsr = 32'h1ACE;
  function automatic bit nxt();
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
    return lfsr[0];
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    @(negedge clk);
    chk("R1", "stall_flag in reset", stall, 0);
    chk("R1", "stall_n in reset", stall_n, 1);
    chk("R1", "recov_irq in reset", irq, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    compare_on = 1;
    tick(LIM - 1);
    @(negedge clk);
    chk("R1", "count starts at zero after reset", stall, 0);
    tick(2);
    @(negedge clk);
    chk("R2", "stall after idle interval", stall, 1);

    @(posedge clk); #1;
    ale = 1'b1;
    for (int k = 1; k <= SYNC + 1; k++) begin
      @(negedge clk);
      chk("R8", $sformatf("stall still set %0d edges after ALE", k), stall, 1);
    end
    @(negedge clk);
    chk("R8", "stall cleared after sync latency", stall, 0);
    chk("R7", "irq on recovery", irq, 1);
    ale = 1'b0; tick(3);

    for (int i = 0; i < 10; i++) pulse(1 + (i % 3), 4);
    @(negedge clk);
    chk("R7", "no irq during normal traffic", irq, 0);

    ale = 1'b1; tick(2 * LIM + 5);
    @(negedge clk);
    chk("R3", "ALE held high still stalls", stall, 1);
    ale = 1'b0; tick(LIM + 5);

    force_en = 1'b1; rdy_req = 1'b0; tick(LIM + 3);
    @(negedge clk);
    chk("R5", "forced ready during stall", rdy, 1);
    force_en = 1'b0; tick(1);
    @(negedge clk);
    chk("R6", "ready follows request when not forced", rdy, 0);
    pulse(2, 6);

    for (int p = LIM - 3; p <= LIM + 4; p++) begin
      for (int j = 0; j < 4; j++) begin
        force_en = nxt();
        rdy_req  = nxt();
        pulse(1 + (j & 1), p - 1 - (j & 1));
      end
    end
    force_en = 1'b1; rdy_req = 1'b0;
    tick(LIM + 6);
    pulse(2, 8);

    compare_on = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule